// File: doc/BRIEF.md
# Doorbell Mailbox Register Bank

This block lets two processors signal each other through single-bit doorbells. There are four instances, and each instance holds 32 channels, for 128 channels in all. Every channel has two bits: a pending bit, which marks a raised event, and an enable bit, which makes that event visible to the receiver. Both bits are changed only through write-one-to-set and write-one-to-clear words. Their current values can be read back through two status words.

A sender raises an event by writing a one into the pending-set word of its channel. The receiver sees a level interrupt. It reads the pending status, clears the bits it has handled, and can mask channels through the enable words. No interrupt tells the sender that a send has completed. A sender treats a channel as free when the enable status shows a one and the pending status shows a zero, and it polls for that condition.

Access goes through an APB-style port with 32-bit words and no wait states. The copies of one register for the four instances sit in consecutive words.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset every pending bit and every enable bit is 0, and `irq` is low.
- R2: A register's byte address is its group base plus 4 × instance. The group bases are: 0x04 pending status (read), 0x24 pending set, 0x44 pending clear, 0x64 enable status (read), 0x84 enable set, 0xA4 enable clear. Bit n of a word is channel n of that instance.
- R3: A write to pending set sets the pending bit of every channel whose data bit is 1. Channels whose data bit is 0 keep their pending bit.
- R4: A write to pending clear clears the pending bit of every channel whose data bit is 1. Channels whose data bit is 0 keep their pending bit.
- R5: Enable set and enable clear act on the enable bits with the same write-one rules. The enable status read returns the current enable mask.
- R6: The pending status read returns raised bits whether or not the channel is enabled.
- R7: `irq` is high exactly when at least one channel in any instance has both its pending bit and its enable bit set. The change is visible in the cycle after the write's access phase.
- R8: Reads of the set and clear addresses return 0.
- R9: An access to an unmapped address reads 0 and changes no bit. Unmapped addresses are: byte address 0x00, anything above 0xBC, any address whose low two bits are not 00, and the instance slots 4 to 7 inside each group (for example 0x14 or 0x34).
- R10: `pready` is high in every cycle, so every access completes in its first access-phase cycle.
- R11: A write addressed to one instance leaves the bits of every other instance unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| psel | input | 1 | Select; marks the setup and access phases |
| penable | input | 1 | High in the access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data, one bit per channel |
| prdata | output | 32 | Read data, valid in the access phase of a read |
| pready | output | 1 | Always high |
| irq | output | 1 | Level interrupt: some enabled channel has an event pending |

## Verification
The assertions assume that the port follows the setup-then-access order. They also assume that no access starts until a couple of cycles after `rst_n` rises, because the internal reset is released two clock edges later. The bench drives every transfer through one task that holds `psel` for one setup and one access cycle. It waits after reset before the first transfer, so the stimulus stays inside these assumptions. The random addresses mix mapped words with arbitrary bytes, which exercises the unmapped holes, misaligned addresses and out-of-range instance slots.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // byte distance between register groups and address of the first group
  localparam int unsigned GROUP_STRIDE = 32'h20;
  localparam int unsigned FIRST_BASE   = 32'h04;
  localparam int unsigned SLOTS        = GROUP_STRIDE / 4;
  localparam int unsigned NUM_GROUPS   = 6;

  typedef enum logic [2:0] {
    K_PEND_VAL = 3'd0,
    K_PEND_SET = 3'd1,
    K_PEND_CLR = 3'd2,
    K_EN_VAL   = 3'd3,
    K_EN_SET   = 3'd4,
    K_EN_CLR   = 3'd5,
    K_NONE     = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int = sync_q[1];
endmodule

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_INST = 4,
  localparam int unsigned INST_W  = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [INST_W-1:0] inst
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic [WORD_W-1:0] word, w_off;
  int unsigned grp, slot;

  always_comb begin
    word  = addr[ADDR_W-1:2];
    w_off = word - WORD_W'(FIRST_BASE / 4);
    grp   = int'(w_off >> SLOT_W);
    slot  = int'(w_off) % SLOTS;
    inst  = INST_W'(slot);
    kind  = K_NONE;
    if (addr[1:0] == 2'b00 && word != '0 && grp < NUM_GROUPS && slot < NUM_INST)
      kind = reg_kind_e'(3'(grp));
  end
endmodule

// File: rtl/mbx_chan_bank.sv
module mbx_chan_bank #(
  parameter int unsigned CHAN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_W-1:0] pend_set,
  input  logic [CHAN_W-1:0] pend_clr,
  input  logic [CHAN_W-1:0] en_set,
  input  logic [CHAN_W-1:0] en_clr,
  output logic [CHAN_W-1:0] pend_q,
  output logic [CHAN_W-1:0] en_q,
  output logic              hit
);
  logic [CHAN_W-1:0] pend_r, pend_nxt, en_r, en_nxt;
  logic              pend_ce, en_ce;

  // clear has priority over set on the same bit
  always_comb begin
    pend_ce  = |(pend_set | pend_clr);
    en_ce    = |(en_set | en_clr);
    pend_nxt = (pend_r | pend_set) & ~pend_clr;
    en_nxt   = (en_r | en_set) & ~en_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_r <= '0;
    else if (pend_ce) pend_r <= pend_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_r <= '0;
    else if (en_ce) en_r <= en_nxt;
  end

  assign pend_q = pend_r;
  assign en_q   = en_r;
  assign hit    = |(pend_r & en_r);
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_INST = 4,
  parameter int unsigned CHAN_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CHAN_W-1:0] pwdata,
  output logic [CHAN_W-1:0] prdata,
  output logic              pready,
  output logic              irq
);
  localparam int unsigned INST_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;

  logic              rst_int;
  logic              acc_wr, acc_rd;
  reg_kind_e         dec_kind;
  logic [INST_W-1:0] dec_inst;
  logic [CHAN_W-1:0] pend_arr [NUM_INST];
  logic [CHAN_W-1:0] en_arr   [NUM_INST];
  logic [NUM_INST-1:0] hit_vec;
  logic [NUM_INST*CHAN_W-1:0] pend_flat, en_flat;
  logic [CHAN_W-1:0] rd_word;

  mbx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_int(rst_int));

  mbx_addr_dec #(.ADDR_W(ADDR_W), .NUM_INST(NUM_INST)) u_dec (
    .addr(paddr), .kind(dec_kind), .inst(dec_inst)
  );

  assign acc_wr = psel & penable & pwrite;
  assign acc_rd = psel & penable & ~pwrite;

  for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_inst
    logic sel;
    logic [CHAN_W-1:0] ps, pc, es, ec;
    always_comb begin
      sel = acc_wr && (dec_inst == INST_W'(gi));
      ps  = (sel && dec_kind == K_PEND_SET) ? pwdata : '0;
      pc  = (sel && dec_kind == K_PEND_CLR) ? pwdata : '0;
      es  = (sel && dec_kind == K_EN_SET)   ? pwdata : '0;
      ec  = (sel && dec_kind == K_EN_CLR)   ? pwdata : '0;
    end
    mbx_chan_bank #(.CHAN_W(CHAN_W)) u_bank (
      .clk(clk), .rst_n(rst_int),
      .pend_set(ps), .pend_clr(pc), .en_set(es), .en_clr(ec),
      .pend_q(pend_arr[gi]), .en_q(en_arr[gi]), .hit(hit_vec[gi])
    );
    assign pend_flat[gi*CHAN_W +: CHAN_W] = pend_arr[gi];
    assign en_flat[gi*CHAN_W +: CHAN_W]   = en_arr[gi];
  end

  always_comb begin
    rd_word = '0;
    unique case (dec_kind)
      K_PEND_VAL: rd_word = pend_arr[dec_inst];
      K_EN_VAL:   rd_word = en_arr[dec_inst];
      default:    rd_word = '0;
    endcase
  end

  assign prdata = acc_rd ? rd_word : '0;
  assign pready = 1'b1;
  assign irq    = |hit_vec;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_INST = 4,
  parameter int unsigned CHAN_W   = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rst_int,
  input logic                       psel,
  input logic                       penable,
  input logic                       pwrite,
  input logic [ADDR_W-1:0]          paddr,
  input logic [CHAN_W-1:0]          pwdata,
  input logic                       irq,
  input logic [NUM_INST*CHAN_W-1:0] pend_all,
  input logic [NUM_INST*CHAN_W-1:0] en_all
);
  logic wr, unmapped;
  int unsigned word, grp, slot;

  always_comb begin
    wr   = psel && penable && pwrite;
    word = int'(paddr) / 4;
    grp  = (word - 1) / SLOTS;
    slot = (word - 1) % SLOTS;
    unmapped = (paddr[1:0] != 2'b00) || (word == 0) || (grp >= NUM_GROUPS) ||
               (slot >= NUM_INST);
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (pend_all == '0 && en_all == '0 && !irq));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(irq) |-> $past(wr));

  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (wr && unmapped) |=> ($stable(pend_all) && $stable(en_all)));

  for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_PSET = ADDR_W'(FIRST_BASE + 1*GROUP_STRIDE + 4*gi);
    localparam logic [ADDR_W-1:0] A_PCLR = ADDR_W'(FIRST_BASE + 2*GROUP_STRIDE + 4*gi);
    localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(FIRST_BASE + 4*GROUP_STRIDE + 4*gi);
    localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(FIRST_BASE + 5*GROUP_STRIDE + 4*gi);

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_int)
      (wr && paddr == A_PSET) |=>
        ((pend_all[gi*CHAN_W +: CHAN_W] & $past(pwdata)) == $past(pwdata)));

    // R4
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_int)
      (wr && paddr == A_PCLR) |=> ((pend_all[gi*CHAN_W +: CHAN_W] & $past(pwdata)) == '0));

    // R5
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_int)
      (wr && paddr == A_ESET) |=>
        ((en_all[gi*CHAN_W +: CHAN_W] & $past(pwdata)) == $past(pwdata)));

    // R5
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_int)
      (wr && paddr == A_ECLR) |=> ((en_all[gi*CHAN_W +: CHAN_W] & $past(pwdata)) == '0));
  end
endmodule

bind doorbell_mbox mbx_chk #(
  .NUM_INST(NUM_INST), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_int(rst_int), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .irq(irq),
  .pend_all(pend_flat), .en_all(en_flat)
);

// File: tb/doorbell_mbox_tb.sv
module doorbell_mbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_pend [4];
  logic [31:0] m_en   [4];

  always #10 clk = ~clk;

  doorbell_mbox u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // kind 0..5 and instance from a byte address, or -1 when unmapped
  function automatic int kind_of(logic [7:0] a);
    int w = int'(a) / 4;
    if (a[1:0] != 0 || w == 0 || (w - 1) / 8 >= 6 || (w - 1) % 8 >= 4) return -1;
    return (w - 1) / 8;
  endfunction
  function automatic int inst_of(logic [7:0] a);
    return ((int'(a) / 4) - 1) % 8;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    int k = kind_of(a);
    if (k == 0) return m_pend[inst_of(a)];
    if (k == 3) return m_en[inst_of(a)];
    return 32'h0;
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int i = 0; i < 4; i++) r |= |(m_pend[i] & m_en[i]);
    return r;
  endfunction

  function automatic string tag_of(logic [7:0] a, logic is_wr);
    case (kind_of(a))
      -1:      return "R9";
      0:       return "R6";
      3:       return "R5";
      default: return is_wr ? "R2" : "R8";
    endcase
  endfunction

  task automatic model_write(logic [7:0] a, logic [31:0] d);
    int k = kind_of(a);
    int i;
    if (k < 0) return;
    i = inst_of(a);
    case (k)
      1: m_pend[i] |= d;
      2: m_pend[i] &= ~d;
      4: m_en[i]   |= d;
      5: m_en[i]   &= ~d;
      default: ;
    endcase
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    model_write(a, d);
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #2 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic read_check(logic [7:0] a, string req);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp_read(a));
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 4; i++) read_check(8'(4 + 32*k + 4*i), req);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin m_pend[i] = '0; m_en[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    check("R1", {31'b0, irq}, 32'h0);
    check("R10", {31'b0, pready}, 32'h1);
    sweep("R1");

    // event on a disabled channel: visible, no interrupt
    bus_write(8'h24, 32'h0000_0005);
    read_check(8'h04, "R6");
    check("R7", {31'b0, irq}, 32'h0);
    read_check(8'h08, "R11");
    // enable one raised channel
    bus_write(8'h84, 32'h0000_0004);
    read_check(8'h64, "R5");
    check("R7", {31'b0, irq}, 32'h1);
    // zero bits leave others alone
    bus_write(8'h24, 32'h0000_0002);
    read_check(8'h04, "R3");
    bus_write(8'h44, 32'h0000_0004);
    read_check(8'h04, "R4");
    check("R7", {31'b0, irq}, 32'h0);
    // other instance, top channel
    bus_write(8'h30, 32'h8000_0000);
    bus_write(8'h90, 32'h8000_0001);
    check("R7", {31'b0, irq}, 32'h1);
    read_check(8'h10, "R11");
    read_check(8'h04, "R11");
    // set and clear addresses read zero
    read_check(8'h24, "R8");
    read_check(8'hA8, "R8");
    check("R10", {31'b0, pready}, 32'h1);
    // unmapped writes and reads
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h34, 32'hFFFF_FFFF);
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_write(8'h25, 32'hFFFF_FFFF);
    bus_write(8'hC4, 32'hFFFF_FFFF);
    bus_write(8'hB4, 32'hFFFF_FFFF);
    sweep("R9");
    read_check(8'h14, "R9");
    read_check(8'h05, "R9");
    read_check(8'hFC, "R9");
    check("R9", {31'b0, irq}, {31'b0, exp_irq()});
    // enable clear
    bus_write(8'hB0, 32'h8000_0000);
    read_check(8'h70, "R5");
    check("R7", {31'b0, irq}, {31'b0, exp_irq()});

    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [7:0]  a;
      logic [31:0] dd;
      if ($urandom % 4 != 0) a = 8'(4 + 32*($urandom % 6) + 4*($urandom % 4));
      else                   a = 8'($urandom);
      dd = $urandom & $urandom & $urandom;
      if ($urandom % 2 == 0) begin
        bus_write(a, dd);
        check("R7", {31'b0, irq}, {31'b0, exp_irq()});
      end else begin
        read_check(a, tag_of(a, 1'b0));
      end
    end
    sweep("R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule